// File: doc/BRIEF.md
# Sequenced Debug Frame Parser

This block sits on the receive side of a byte-wide debug link and cuts the incoming stream into messages. Every message opens with a fixed nine-byte header: a four-element array marker, a tagged 16-bit total length, a tagged 16-bit sequence number, a one-byte acknowledgement flag and a map marker. The parser checks each header byte against the value it must hold. It publishes the decoded fields and then forwards the remaining payload bytes, marking the first and the last of them. The block does not interpret the map contents.

Alignment does not depend on a raw length prefix. While idle, the parser discards every byte until it sees the array marker. Any header byte with the wrong value raises a single-cycle framing error and sends the parser back to hunting. Each accepted header's sequence number is compared with the last one accepted, using modular subtraction over half the 16-bit space. A forward jump larger than one reports the missing range. A number that equals or trails the last one is reported as a duplicate, and its payload is dropped.

Top module: `dbg_frame_parser`

## Requirements
- R1: While `rst_n` is low, `inReady`, `outValid`, `hdrValid`, `frameErr`, `gapPulse` and `dupPulse` are low. `inReady` is high once reset has been released.
- R2: While hunting, every byte other than 0x84 is dropped. Such a byte raises no `frameErr` and produces no output.
- R3: The header must be 0x84, then 0x19, length high, length low, then 0x19, sequence high, sequence low, then a flag byte (0xF5 or 0xF4), then a map byte (0xA1 or 0xA2). A wrong tag, flag or map byte gives exactly one `frameErr` pulse and no `hdrValid`. The offending byte is discarded, and the sequence state is left untouched.
- R4: A declared length below 9 is a framing error, reported as in R3.
- R5: Both 16-bit fields are big-endian. One cycle after the map byte is accepted, a one-cycle `hdrValid` presents `hdrLength`, `hdrSeq`, `hdrAckReq` (1 for 0xF5, 0 for 0xF4) and `hdrHasBody` (1 for 0xA2, 0 for 0xA1).
- R6: After the header, exactly length−9 bytes are forwarded on `outData`. Each appears with `outValid` one cycle after it is accepted. `outFirst` marks the first forwarded byte and `outLast` the final one. A length of 9 forwards nothing.
- R7: Let d = sequence − last accepted sequence, taken mod 2^16. When d lies in 2..0x7FFF, the frame is accepted and `gapPulse` fires together with `hdrValid`, with `gapFirst` = last+1 and `gapLast` = sequence−1.
- R8: When d is 0 or at least 0x8000, `dupPulse` fires in place of `hdrValid`. The frame's payload is consumed but not forwarded, and the last accepted sequence is left unchanged.
- R9: Sequence 0x0000 after 0xFFFF has d = 1 and is accepted with no gap.
- R10: The first header accepted after reset raises neither a gap nor a duplicate.
- R11: Cycles with `inValid` low inside a frame have no effect on parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Parser accepts a byte this cycle |
| outValid | output | 1 | Payload byte valid |
| outData | output | 8 | Payload byte |
| outFirst | output | 1 | First payload byte of a frame |
| outLast | output | 1 | Last payload byte of a frame |
| hdrValid | output | 1 | Header accepted, fields valid this cycle |
| hdrLength | output | 16 | Declared total message length |
| hdrSeq | output | 16 | Message sequence number |
| hdrAckReq | output | 1 | Acknowledgement requested |
| hdrHasBody | output | 1 | Map marker says a body follows |
| frameErr | output | 1 | Header byte mismatch or short length |
| gapPulse | output | 1 | Sequence skipped ahead |
| gapFirst | output | 16 | First missing sequence number |
| gapLast | output | 16 | Last missing sequence number |
| dupPulse | output | 1 | Duplicate or stale frame dropped |

## Verification
The assertions watch rules that hold on every cycle. A framing error never coincides with a header or payload output. A gap always arrives with its header, ends just below the new sequence number and spans less than half the sequence space. A duplicate never publishes a header. Published lengths are never below the header size. Payload only appears after an accepted input byte.

The actual sequence arithmetic can only be shown by the bench's scenarios, which drive frame sequences from a table. These cover in-order runs, forward jumps, exact repeats, stale numbers, the half-space boundary and the wrap through 0xFFFF. The bench's directed cases cover payload counts, boundary markers, big-endian lengths, stray leading bytes and each kind of header corruption.

// File: rtl/dbg_frame_pkg.sv
package dbg_frame_pkg;
  localparam logic [7:0] BYTE_START     = 8'h84;
  localparam logic [7:0] BYTE_U16       = 8'h19;
  localparam logic [7:0] BYTE_ACK_ON    = 8'hF5;
  localparam logic [7:0] BYTE_ACK_OFF   = 8'hF4;
  localparam logic [7:0] BYTE_MAP_EMPTY = 8'hA1;
  localparam logic [7:0] BYTE_MAP_BODY  = 8'hA2;
  localparam int         HDR_BYTES      = 9;
  localparam int         FIELD_W        = 16;

  typedef enum logic [3:0] {
    ST_HUNT, ST_LTAG, ST_LHI, ST_LLO, ST_STAG,
    ST_SHI, ST_SLO, ST_FLAG, ST_MAP, ST_BODY
  } parse_st_t;

  typedef struct packed {
    logic lenHi;
    logic lenLo;
    logic seqHi;
    logic seqLo;
    logic flag;
    logic mapOk;
    logic body;
    logic err;
  } ctl_strobe_t;
endpackage

// File: rtl/dbg_frame_ctl.sv
module dbg_frame_ctl
  import dbg_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  byteIn,
  input  logic        lenShort,
  input  logic        noPayload,
  input  logic        lastBody,
  output ctl_strobe_t strobe
);
  parse_st_t st, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_HUNT;
    else        st <= nxt;
  end

  always_comb begin
    nxt    = st;
    strobe = '0;
    if (take) begin
      case (st)
        ST_HUNT: if (byteIn == BYTE_START) nxt = ST_LTAG;
        ST_LTAG: begin
          if (byteIn == BYTE_U16) nxt = ST_LHI;
          else begin strobe.err = 1'b1; nxt = ST_HUNT; end
        end
        ST_LHI: begin strobe.lenHi = 1'b1; nxt = ST_LLO; end
        ST_LLO: begin
          if (lenShort) begin strobe.err = 1'b1; nxt = ST_HUNT; end
          else begin strobe.lenLo = 1'b1; nxt = ST_STAG; end
        end
        ST_STAG: begin
          if (byteIn == BYTE_U16) nxt = ST_SHI;
          else begin strobe.err = 1'b1; nxt = ST_HUNT; end
        end
        ST_SHI: begin strobe.seqHi = 1'b1; nxt = ST_SLO; end
        ST_SLO: begin strobe.seqLo = 1'b1; nxt = ST_FLAG; end
        ST_FLAG: begin
          if (byteIn == BYTE_ACK_ON || byteIn == BYTE_ACK_OFF) begin
            strobe.flag = 1'b1; nxt = ST_MAP;
          end else begin strobe.err = 1'b1; nxt = ST_HUNT; end
        end
        ST_MAP: begin
          if (byteIn == BYTE_MAP_EMPTY || byteIn == BYTE_MAP_BODY) begin
            strobe.mapOk = 1'b1;
            nxt = noPayload ? ST_HUNT : ST_BODY;
          end else begin strobe.err = 1'b1; nxt = ST_HUNT; end
        end
        ST_BODY: begin
          strobe.body = 1'b1;
          if (lastBody) nxt = ST_HUNT;
        end
        default: nxt = ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/dbg_frame_dp.sv
module dbg_frame_dp
  import dbg_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctl_strobe_t        strobe,
  input  logic [7:0]         byteIn,
  output logic               lenShort,
  output logic               noPayload,
  output logic               lastBody,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic               outFirst,
  output logic               outLast,
  output logic               hdrValid,
  output logic [FIELD_W-1:0] hdrLength,
  output logic [FIELD_W-1:0] hdrSeq,
  output logic               hdrAckReq,
  output logic               hdrHasBody,
  output logic               frameErr,
  output logic               gapPulse,
  output logic [FIELD_W-1:0] gapFirst,
  output logic [FIELD_W-1:0] gapLast,
  output logic               dupPulse
);
  localparam logic [FIELD_W-1:0] HDR_LEN = FIELD_W'(HDR_BYTES);
  localparam logic [FIELD_W-1:0] ONE     = FIELD_W'(1);

  logic [7:0]         lenHiQ, seqHiQ;
  logic [FIELD_W-1:0] lenQ, seqQ, lastSeq, remaining, seqDiff;
  logic               ackQ, haveLast, dropQ, firstPend, isDup, isGap;

  assign lenShort  = {lenHiQ, byteIn} < HDR_LEN;
  assign noPayload = (lenQ == HDR_LEN);
  assign lastBody  = (remaining == ONE);
  assign seqDiff   = seqQ - lastSeq;
  assign isDup     = haveLast && (seqDiff == '0 || seqDiff[FIELD_W-1]);
  assign isGap     = haveLast && !isDup && (seqDiff != ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenHiQ <= '0; seqHiQ <= '0; lenQ <= '0; seqQ <= '0;
      lastSeq <= '0; remaining <= '0; ackQ <= 1'b0; haveLast <= 1'b0;
      dropQ <= 1'b0; firstPend <= 1'b0;
      outValid <= 1'b0; outData <= '0; outFirst <= 1'b0; outLast <= 1'b0;
      hdrValid <= 1'b0; hdrLength <= '0; hdrSeq <= '0;
      hdrAckReq <= 1'b0; hdrHasBody <= 1'b0; frameErr <= 1'b0;
      gapPulse <= 1'b0; gapFirst <= '0; gapLast <= '0; dupPulse <= 1'b0;
    end else begin
      outValid <= 1'b0; outFirst <= 1'b0; outLast <= 1'b0;
      hdrValid <= 1'b0; gapPulse <= 1'b0; dupPulse <= 1'b0;
      frameErr <= strobe.err;
      if (strobe.lenHi) lenHiQ <= byteIn;
      if (strobe.lenLo) lenQ   <= {lenHiQ, byteIn};
      if (strobe.seqHi) seqHiQ <= byteIn;
      if (strobe.seqLo) seqQ   <= {seqHiQ, byteIn};
      if (strobe.flag)  ackQ   <= (byteIn == BYTE_ACK_ON);
      if (strobe.mapOk) begin
        remaining <= lenQ - HDR_LEN;
        dropQ     <= isDup;
        firstPend <= 1'b1;
        if (isDup) begin
          dupPulse <= 1'b1;
        end else begin
          lastSeq    <= seqQ;
          haveLast   <= 1'b1;
          hdrValid   <= 1'b1;
          hdrLength  <= lenQ;
          hdrSeq     <= seqQ;
          hdrAckReq  <= ackQ;
          hdrHasBody <= (byteIn == BYTE_MAP_BODY);
          if (isGap) begin
            gapPulse <= 1'b1;
            gapFirst <= lastSeq + ONE;
            gapLast  <= seqQ - ONE;
          end
        end
      end
      if (strobe.body) begin
        remaining <= remaining - ONE;
        firstPend <= 1'b0;
        if (!dropQ) begin
          outValid <= 1'b1;
          outData  <= byteIn;
          outFirst <= firstPend;
          outLast  <= (remaining == ONE);
        end
      end
    end
  end
endmodule

// File: rtl/dbg_frame_parser.sv
module dbg_frame_parser
  import dbg_frame_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        outFirst,
  output logic        outLast,
  output logic        hdrValid,
  output logic [15:0] hdrLength,
  output logic [15:0] hdrSeq,
  output logic        hdrAckReq,
  output logic        hdrHasBody,
  output logic        frameErr,
  output logic        gapPulse,
  output logic [15:0] gapFirst,
  output logic [15:0] gapLast,
  output logic        dupPulse
);
  ctl_strobe_t strobe;
  logic        lenShort, noPayload, lastBody, readyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyQ <= 1'b0;
    else        readyQ <= 1'b1;
  end
  assign inReady = readyQ;

  dbg_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .take(inValid && readyQ), .byteIn(inData),
    .lenShort(lenShort), .noPayload(noPayload), .lastBody(lastBody),
    .strobe(strobe)
  );

  dbg_frame_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .byteIn(inData),
    .lenShort(lenShort), .noPayload(noPayload), .lastBody(lastBody),
    .outValid(outValid), .outData(outData), .outFirst(outFirst),
    .outLast(outLast), .hdrValid(hdrValid), .hdrLength(hdrLength),
    .hdrSeq(hdrSeq), .hdrAckReq(hdrAckReq), .hdrHasBody(hdrHasBody),
    .frameErr(frameErr), .gapPulse(gapPulse), .gapFirst(gapFirst),
    .gapLast(gapLast), .dupPulse(dupPulse)
  );
endmodule

// File: rtl/dbg_frame_parser_chk.sv
module dbg_frame_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outFirst,
  input logic        outLast,
  input logic        hdrValid,
  input logic [15:0] hdrLength,
  input logic [15:0] hdrSeq,
  input logic        frameErr,
  input logic        gapPulse,
  input logic [15:0] gapFirst,
  input logic [15:0] gapLast,
  input logic        dupPulse
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !inReady && !outValid && !hdrValid && !frameErr); // R1
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n) frameErr |-> !outValid && !hdrValid && !dupPulse); // R3
  AST_HDR_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n) hdrValid |-> hdrLength >= 16'd9); // R4
  AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n) outValid |-> $past(inValid && inReady)); // R6
  AST_MARK_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n) (outFirst || outLast) |-> outValid); // R6
  AST_GAP_WITH_HDR: assert property (@(posedge clk) disable iff (!rst_n) gapPulse |-> hdrValid && (gapLast + 16'd1 == hdrSeq)); // R7
  AST_GAP_SPAN: assert property (@(posedge clk) disable iff (!rst_n) gapPulse |-> (gapLast - gapFirst) <= 16'h7FFD); // R7
  AST_DUP_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n) dupPulse |-> !hdrValid && !gapPulse); // R8
endmodule

bind dbg_frame_parser dbg_frame_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
  .hdrValid(hdrValid), .hdrLength(hdrLength), .hdrSeq(hdrSeq),
  .frameErr(frameErr), .gapPulse(gapPulse), .gapFirst(gapFirst),
  .gapLast(gapLast), .dupPulse(dupPulse)
);

// File: tb/dbg_frame_parser_tb.sv
module dbg_frame_parser_tb;
  logic clk = 1'b0, rst_n = 1'b0, inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, outValid, outFirst, outLast, hdrValid, hdrAckReq, hdrHasBody;
  logic frameErr, gapPulse, dupPulse;
  logic [7:0] outData;
  logic [15:0] hdrLength, hdrSeq, gapFirst, gapLast;

  always #4 clk = ~clk;

  dbg_frame_parser u_dut (.*);

  int compared = 0, mismatched = 0;

  typedef struct packed {
    logic [15:0] seq;
    logic [7:0]  plen;
    logic        ack;
    logic        body;
    logic        dup;
    logic        gap;
    logic [15:0] gFirst;
    logic [15:0] gLast;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0005, 8'd3,   1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R10 first
    '{16'h0006, 8'd0,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{16'h0009, 8'd2,   1'b1, 1'b1, 1'b0, 1'b1, 16'h0007, 16'h0008},
    '{16'h0009, 8'd2,   1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000},
    '{16'h0004, 8'd1,   1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000},
    '{16'h000A, 8'd1,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    '{16'h800A, 8'd2,   1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000},
    '{16'h8009, 8'd4,   1'b0, 1'b1, 1'b0, 1'b1, 16'h000B, 16'h8008},
    '{16'hFFFF, 8'd1,   1'b1, 1'b1, 1'b0, 1'b1, 16'h800A, 16'hFFFE},
    '{16'h0000, 8'd2,   1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R9 wrap
    '{16'h0002, 8'd1,   1'b1, 1'b0, 1'b0, 1'b1, 16'h0001, 16'h0001},
    '{16'h0003, 8'd250, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  // monitor state
  int pCnt, firstCnt, lastCnt, firstIdx, lastIdx, dataBad, hdrCnt, gapCnt, dupCnt, errCnt;
  logic [15:0] mLen, mSeq, mGf, mGl;
  logic mAck, mBody;
  logic [7:0] expBase;

  task automatic clrMon(input logic [7:0] base);
    pCnt = 0; firstCnt = 0; lastCnt = 0; firstIdx = -1; lastIdx = -1; dataBad = 0;
    hdrCnt = 0; gapCnt = 0; dupCnt = 0; errCnt = 0; expBase = base;
  endtask

  always @(posedge clk) begin
    #2;
    if (outValid) begin
      if (outData != 8'(expBase + 8'(pCnt))) dataBad++;
      if (outFirst) begin firstCnt++; firstIdx = pCnt; end
      if (outLast) begin lastCnt++; lastIdx = pCnt; end
      pCnt++;
    end
    if (hdrValid) begin
      hdrCnt++; mLen = hdrLength; mSeq = hdrSeq; mAck = hdrAckReq; mBody = hdrHasBody;
    end
    if (gapPulse) begin gapCnt++; mGf = gapFirst; mGl = gapLast; end
    if (dupPulse) dupCnt++;
    if (frameErr) errCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic bubble);
    inValid = 1'b1; inData = b;
    @(negedge clk);
    inValid = 1'b0;
    if (bubble) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [15:0] seq, input logic [7:0] plen,
                           input logic [7:0] flagB, input logic [7:0] mapB,
                           input logic bubble);
    logic [15:0] len;
    len = 16'd9 + 16'(plen);
    sendByte(8'h84, bubble); sendByte(8'h19, bubble);
    sendByte(len[15:8], bubble); sendByte(len[7:0], bubble);
    sendByte(8'h19, bubble); sendByte(seq[15:8], bubble); sendByte(seq[7:0], bubble);
    sendByte(flagB, bubble); sendByte(mapB, bubble);
    for (int i = 0; i < int'(plen); i++) sendByte(8'(seq[7:0] + 8'(i)), bubble);
    repeat (3) @(negedge clk);
  endtask

  task automatic sendRaw(input logic [7:0] bytes [], input int n);
    for (int i = 0; i < n; i++) sendByte(bytes[i], 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] raw [];
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 inReady in reset", 32'(inReady), 0);
    chk("R1 outValid in reset", 32'(outValid), 0);
    chk("R1 hdrValid in reset", 32'(hdrValid), 0);
    chk("R1 frameErr in reset", 32'(frameErr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 inReady after reset", 32'(inReady), 1);

    // table walk: R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      clrMon(VECS[v].seq[7:0]);
      sendFrame(VECS[v].seq, VECS[v].plen, VECS[v].ack ? 8'hF5 : 8'hF4,
                VECS[v].body ? 8'hA2 : 8'hA1, 1'(v % 2)); // odd rows use bubbles, R11
      chk("R8 dup count", 32'(dupCnt), 32'(VECS[v].dup));
      chk("R5 hdr count", 32'(hdrCnt), VECS[v].dup ? 0 : 1);
      chk("R7 gap count", 32'(gapCnt), 32'(VECS[v].gap));
      chk("R3 no error", 32'(errCnt), 0);
      chk("R6 payload count", 32'(pCnt), VECS[v].dup ? 0 : 32'(VECS[v].plen));
      chk("R6 payload data", 32'(dataBad), 0);
      if (!VECS[v].dup) begin
        chk("R5 seq", 32'(mSeq), 32'(VECS[v].seq));
        chk("R5 length", 32'(mLen), 32'(16'd9 + 16'(VECS[v].plen)));
        chk("R5 ack", 32'(mAck), 32'(VECS[v].ack));
        chk("R5 body", 32'(mBody), 32'(VECS[v].body));
        if (VECS[v].plen != 0) begin
          chk("R6 first idx", 32'(firstIdx), 0);
          chk("R6 last idx", 32'(lastIdx), 32'(VECS[v].plen) - 1);
          chk("R6 first count", 32'(firstCnt), 1);
          chk("R6 last count", 32'(lastCnt), 1);
        end
      end
      if (VECS[v].gap) begin
        chk("R7 gap first", 32'(mGf), 32'(VECS[v].gFirst));
        chk("R7 gap last", 32'(mGl), 32'(VECS[v].gLast));
      end
    end

    // R2 stray bytes before a frame
    clrMon(8'h04);
    raw = '{8'h00, 8'h55, 8'hA2, 8'h19};
    sendRaw(raw, 4);
    chk("R2 stray no error", 32'(errCnt), 0);
    chk("R2 stray no output", 32'(pCnt + hdrCnt), 0);
    sendFrame(16'h0004, 8'd2, 8'hF5, 8'hA2, 1'b0);
    chk("R2 frame after strays", 32'(hdrCnt), 1);
    chk("R2 payload after strays", 32'(pCnt), 2);

    // R3 bad length tag
    clrMon(8'h00);
    raw = '{8'h84, 8'h18};
    sendRaw(raw, 2);
    chk("R3 bad length tag err", 32'(errCnt), 1);
    chk("R3 bad length tag hdr", 32'(hdrCnt), 0);
    // R3 bad sequence tag
    clrMon(8'h00);
    raw = '{8'h84, 8'h19, 8'h00, 8'h0A, 8'h1A};
    sendRaw(raw, 5);
    chk("R3 bad seq tag err", 32'(errCnt), 1);
    // R3 bad flag byte
    clrMon(8'h00);
    raw = '{8'h84, 8'h19, 8'h00, 8'h0A, 8'h19, 8'h00, 8'h09, 8'h00};
    sendRaw(raw, 8);
    chk("R3 bad flag err", 32'(errCnt), 1);
    chk("R3 bad flag hdr", 32'(hdrCnt), 0);
    // R3 bad map byte
    clrMon(8'h00);
    raw = '{8'h84, 8'h19, 8'h00, 8'h0A, 8'h19, 8'h00, 8'h09, 8'hF5, 8'hA3};
    sendRaw(raw, 9);
    chk("R3 bad map err", 32'(errCnt), 1);
    chk("R3 bad map hdr", 32'(hdrCnt + dupCnt + gapCnt), 0);
    // R4 short lengths
    clrMon(8'h00);
    raw = '{8'h84, 8'h19, 8'h00, 8'h08};
    sendRaw(raw, 4);
    chk("R4 length 8 err", 32'(errCnt), 1);
    clrMon(8'h00);
    raw = '{8'h84, 8'h19, 8'h00, 8'h00};
    sendRaw(raw, 4);
    chk("R4 length 0 err", 32'(errCnt), 1);

    // R3 recovery, sequence state untouched by errors
    clrMon(8'h05);
    sendFrame(16'h0005, 8'd1, 8'hF4, 8'hA1, 1'b0);
    chk("R3 recover hdr", 32'(hdrCnt), 1);
    chk("R3 recover no gap", 32'(gapCnt + dupCnt), 0);
    chk("R6 single byte first+last", 32'(firstCnt + lastCnt), 2);

    finishRun();
  end
endmodule